// File: doc/BRIEF.md
# Processor Status Flags Register

This block is the status word of a small 8-bit processor core. It keeps four arithmetic flags (carry, half carry, zero, overflow) that the ALU updates after an operation or that software overwrites by storing to the register's data address. It also keeps two protected flags that report why the core is running: one records that a sleep was entered, the other records that the watchdog expired. Only the system events change these two flags. The halt, clear-watchdog and watchdog-expiry pulses each follow fixed set and clear rules, and a software store cannot reach them.

The core reads the register back as one byte. The arithmetic flags sit in the low nibble, the two protected flags above them, and the top two bits always read zero. A power-up reset clears the whole word. The watchdog timer and the halt/wake sequencing are outside this block; it only receives their single-cycle pulses.

Top module: `status_flags_reg`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it is released, `statusRd` reads 0x00.
- R2: `statusRd` bit 0 is carry, bit 1 half carry, bit 2 zero, bit 3 overflow, bit 4 the sleep flag and bit 5 the watchdog-expiry flag. Bits 7 and 6 always read 0.
- R3: When `aluUpdEn[i]` is high (i = 0..3, same order as the bits of R2), flag i takes `aluFlagVal[i]` at the next clock edge. Flags whose enable is low keep their value.
- R4: A store with `swWrEn` high and `swAddr` equal to 0x0A loads `swWrData[3:0]` into bits 3:0 at the next clock edge.
- R5: A store to any address other than 0x0A changes no bit of `statusRd`.
- R6: A store to 0x0A never changes bits 5 and 4, whatever `swWrData[5:4]` holds.
- R7: When a store to 0x0A and ALU updates occur in the same cycle, all four arithmetic flags take the stored data.
- R8: `haltPulse` sets the sleep flag (bit 4) and clears the watchdog-expiry flag (bit 5).
- R9: `clrWdtPulse` clears both the sleep flag and the watchdog-expiry flag.
- R10: `wdtTimeoutPulse` sets the watchdog-expiry flag. It wins over a halt or clear-watchdog pulse in the same cycle.
- R11: When `haltPulse` and `clrWdtPulse` occur in the same cycle, the sleep flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Power-up reset, active low, asynchronous |
| aluUpdEn | input | 4 | Per-flag ALU update enable |
| aluFlagVal | input | 4 | Per-flag ALU result value |
| swWrEn | input | 1 | Software store strobe |
| swAddr | input | 8 | Software store data address |
| swWrData | input | 8 | Software store data |
| haltPulse | input | 1 | Halt instruction executed |
| clrWdtPulse | input | 1 | Clear-watchdog instruction executed |
| wdtTimeoutPulse | input | 1 | Watchdog expired |
| statusRd | output | 8 | Status readback |

## Verification
The assertions check the following on every cycle:
- the top two bits stay zero;
- the protected flags hold unless an event strobe reaches them;
- the arithmetic flags hold when nothing loads them;
- a winning software store lands exactly;
- a halt or expiry strobe is always reflected one cycle later.

Only the bench scenarios can show the rest:
- that the address decode rejects other addresses;
- that the ALU per-bit enables hit the intended positions;
- the same-cycle priority outcomes between the event pulses.

// File: rtl/status_pkg.sv
package status_pkg;
  localparam int ARITH_FLAGS = 4;
  localparam int PDF_BIT = ARITH_FLAGS;
  localparam int TO_BIT = ARITH_FLAGS + 1;

  typedef struct packed {
    logic [ARITH_FLAGS-1:0] arithLoad;
    logic arithFromSw;
    logic pdfSet;
    logic pdfClr;
    logic toSet;
    logic toClr;
  } flagStrobes_t;
endpackage

// File: rtl/status_ctrl.sv
module status_ctrl
  import status_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h0A
) (
  input  logic                   swWrEn,
  input  logic [ADDR_W-1:0]      swAddr,
  input  logic [ARITH_FLAGS-1:0] aluUpdEn,
  input  logic                   haltPulse,
  input  logic                   clrWdtPulse,
  input  logic                   wdtTimeoutPulse,
  output flagStrobes_t           strobes
);
  logic wrHit;

  always_comb begin
    wrHit = swWrEn && (swAddr == STATUS_ADDR);
    // A store claims every arithmetic flag, overriding the ALU.
    strobes.arithLoad = wrHit ? '1 : aluUpdEn;
    strobes.arithFromSw = wrHit;
    // Sleep flag: halt sets, and wins over clear-watchdog.
    strobes.pdfSet = haltPulse;
    strobes.pdfClr = clrWdtPulse && !haltPulse;
    // Expiry flag: timeout sets, and wins over both clearing events.
    strobes.toSet = wdtTimeoutPulse;
    strobes.toClr = (clrWdtPulse || haltPulse) && !wdtTimeoutPulse;
  end
endmodule

// File: rtl/status_datapath.sv
module status_datapath
  import status_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  flagStrobes_t           strobes,
  input  logic [ARITH_FLAGS-1:0] aluFlagVal,
  input  logic [ARITH_FLAGS-1:0] swFlagData,
  output logic [DATA_W-1:0]      statusWord
);
  localparam int PAD_W = DATA_W - ARITH_FLAGS - 2;

  logic [ARITH_FLAGS-1:0] arithQ;
  logic pdfQ;
  logic toQ;

  for (genvar i = 0; i < ARITH_FLAGS; i++) begin : g_arith
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) arithQ[i] <= 1'b0;
      else if (strobes.arithLoad[i])
        arithQ[i] <= strobes.arithFromSw ? swFlagData[i] : aluFlagVal[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pdfQ <= 1'b0;
      toQ <= 1'b0;
    end else begin
      if (strobes.pdfSet) pdfQ <= 1'b1;
      else if (strobes.pdfClr) pdfQ <= 1'b0;
      if (strobes.toSet) toQ <= 1'b1;
      else if (strobes.toClr) toQ <= 1'b0;
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[ARITH_FLAGS-1:0] = arithQ;
    statusWord[PDF_BIT] = pdfQ;
    statusWord[TO_BIT] = toQ;
  end

  assert_pad_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[DATA_W-1:DATA_W-PAD_W] == '0);
  assert_protected_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.pdfSet || strobes.pdfClr || strobes.toSet || strobes.toClr)
      |=> $stable({pdfQ, toQ}));
  assert_arith_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.arithLoad == '0) |=> $stable(arithQ));
  assert_sw_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.arithFromSw |=> (arithQ == $past(swFlagData)));
  assert_halt_sets_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pdfSet |=> pdfQ);
  assert_timeout_sets_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.toSet |=> toQ);
endmodule

// File: rtl/status_flags_reg.sv
module status_flags_reg
  import status_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h0A
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ARITH_FLAGS-1:0] aluUpdEn,
  input  logic [ARITH_FLAGS-1:0] aluFlagVal,
  input  logic                   swWrEn,
  input  logic [ADDR_W-1:0]      swAddr,
  input  logic [DATA_W-1:0]      swWrData,
  input  logic                   haltPulse,
  input  logic                   clrWdtPulse,
  input  logic                   wdtTimeoutPulse,
  output logic [DATA_W-1:0]      statusRd
);
  flagStrobes_t strobes;
  logic unusedHiData;

  assign unusedHiData = ^swWrData[DATA_W-1:ARITH_FLAGS];

  status_ctrl #(.ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR)) i_ctrl (
    .swWrEn(swWrEn),
    .swAddr(swAddr),
    .aluUpdEn(aluUpdEn),
    .haltPulse(haltPulse),
    .clrWdtPulse(clrWdtPulse),
    .wdtTimeoutPulse(wdtTimeoutPulse),
    .strobes(strobes)
  );

  status_datapath #(.DATA_W(DATA_W)) i_dp (
    .clk(clk),
    .rstN(rstN),
    .strobes(strobes),
    .aluFlagVal(aluFlagVal),
    .swFlagData(swWrData[ARITH_FLAGS-1:0]),
    .statusWord(statusRd)
  );
endmodule

// File: tb/test_status_flags_reg.sv
module test_status_flags_reg;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] aluUpdEn = '0;
  logic [3:0] aluFlagVal = '0;
  logic swWrEn = 1'b0;
  logic [7:0] swAddr = '0;
  logic [7:0] swWrData = '0;
  logic haltPulse = 1'b0;
  logic clrWdtPulse = 1'b0;
  logic wdtTimeoutPulse = 1'b0;
  logic [7:0] statusRd;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  status_flags_reg i_status_flags_reg (
    .clk(clk), .rstN(rstN), .aluUpdEn(aluUpdEn), .aluFlagVal(aluFlagVal),
    .swWrEn(swWrEn), .swAddr(swAddr), .swWrData(swWrData),
    .haltPulse(haltPulse), .clrWdtPulse(clrWdtPulse),
    .wdtTimeoutPulse(wdtTimeoutPulse), .statusRd(statusRd)
  );

  task automatic check(input string req, input logic [7:0] expected);
    checks++;
    if (statusRd !== expected) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, statusRd, expected);
    end
  endtask

  // Drive one cycle of stimulus at a falling edge, release it at the next.
  task automatic step(input logic [3:0] en, input logic [3:0] val,
                      input logic wr, input logic [7:0] addr, input logic [7:0] data,
                      input logic halt, input logic clr, input logic tmo);
    aluUpdEn = en; aluFlagVal = val; swWrEn = wr; swAddr = addr; swWrData = data;
    haltPulse = halt; clrWdtPulse = clr; wdtTimeoutPulse = tmo;
    @(negedge clk);
    aluUpdEn = '0; aluFlagVal = '0; swWrEn = 1'b0; swAddr = '0; swWrData = '0;
    haltPulse = 1'b0; clrWdtPulse = 1'b0; wdtTimeoutPulse = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 in reset", 8'h00);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", 8'h00);
  endtask

  task automatic t_alu;
    step(4'b0101, 4'b1111, 0, 8'h00, 8'h00, 0, 0, 0);
    check("R3 carry and zero", 8'h05);
    step(4'b1010, 4'b1010, 0, 8'h00, 8'h00, 0, 0, 0);
    check("R3 half carry and overflow", 8'h0F);
    step(4'b0001, 4'b0000, 0, 8'h00, 8'h00, 0, 0, 0);
    check("R3 clear carry only", 8'h0E);
  endtask

  task automatic t_store;
    step('0, '0, 1, 8'h0A, 8'hFF, 0, 0, 0);
    check("R4 R6 R2 store all ones", 8'h0F);
    step('0, '0, 1, 8'h0A, 8'h30, 0, 0, 0);
    check("R4 R6 store protected bits only", 8'h00);
    step('0, '0, 0, 8'h00, 8'h00, 1, 0, 0);
    check("R8 halt from clear", 8'h10);
    step('0, '0, 1, 8'h0A, 8'h20, 0, 0, 0);
    check("R6 store cannot move sleep/expiry", 8'h10);
    step('0, '0, 1, 8'h0B, 8'h05, 0, 0, 0);
    check("R5 store to other address", 8'h10);
    step('0, '0, 1, 8'h0A, 8'h05, 0, 0, 0);
    check("R4 store keeps sleep flag", 8'h15);
  endtask

  task automatic t_collide;
    step(4'b1111, 4'b0000, 1, 8'h0A, 8'h09, 0, 0, 0);
    check("R7 store beats ALU", 8'h19);
  endtask

  task automatic t_events;
    step('0, '0, 0, 8'h00, 8'h00, 0, 0, 1);
    check("R10 timeout sets expiry", 8'h39);
    step('0, '0, 0, 8'h00, 8'h00, 0, 1, 0);
    check("R9 clear-watchdog clears both", 8'h09);
    step('0, '0, 0, 8'h00, 8'h00, 0, 0, 1);
    check("R10 timeout again", 8'h29);
    step('0, '0, 0, 8'h00, 8'h00, 1, 0, 0);
    check("R8 halt sets sleep clears expiry", 8'h19);
    step('0, '0, 0, 8'h00, 8'h00, 0, 1, 1);
    check("R10 timeout beats clear-watchdog", 8'h29);
    step('0, '0, 0, 8'h00, 8'h00, 1, 1, 0);
    check("R11 halt beats clear-watchdog", 8'h19);
    step('0, '0, 0, 8'h00, 8'h00, 1, 0, 1);
    check("R10 timeout beats halt", 8'h39);
  endtask

  task automatic t_reset_again;
    rstN = 1'b0;
    #1;
    check("R1 asynchronous clear", 8'h00);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check("R1 released again", 8'h00);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_alu();
    t_store();
    t_collide();
    t_events();
    t_reset_again();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule